// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Status Register Block

This block gathers the event indications of a serial bus controller into one interrupt register set. Twelve sources feed a raw status register. A mask register selects which sources reach a masked status view and a single interrupt line. Software clears a source by reading a dedicated clear address. Each source has its own clear address, so clearing one event cannot drop another that arrived just before. A combined clear address drops every clearable source at once.

Beside the status bits, the block keeps a capture register of transmit abort reasons. New reason bits OR into it every cycle. Any nonzero reason vector raises the transmit-abort source. Reading the transmit-abort clear address empties the capture along with the status bit. The receive-threshold and transmit-threshold sources are levels from FIFO comparisons. They follow their inputs directly and ignore clear reads.

Read data is combinational from the current address while the read strobe is high. Clear side effects take effect at the clock edge that ends the read cycle.

Top module: `irq_status_regs`

## Requirements
- R1: After reset the raw status, mask, masked status and abort capture all read zero, and `irq` is low.
- R2: Source bit positions are fixed: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A high on `src_evt[i]` for any bit other than 2 and 4 sets raw bit i at the next edge. The raw status reads at address 0x34.
- R3: Raw bits 2 and 4 equal `src_evt[2]` and `src_evt[4]` in the same cycle. No clear read changes them.
- R4: A write to 0x30 loads the mask from `wdata`, and reading 0x30 returns it. Reading 0x2C returns the raw status ANDed with the mask.
- R5: `irq` is high exactly when some masked status bit is set.
- R6: The ten clearable sources (bits 0,1,3,5,6,7,8,9,10,11, in that order) have clear addresses 0x44, 0x48, and onward in steps of 4, ending at 0x68. Reading one clears only that raw bit.
- R7: Reading 0x40 clears every clearable raw bit.
- R8: If a source event arrives in the same cycle as a clear read of its bit, the bit stays set.
- R9: The abort capture at 0x80 ORs in `abort_vec` every cycle. A nonzero `abort_vec` sets raw bit 6 at the next edge.
- R10: Reading 0x54 empties the abort capture, keeping only reason bits that arrive in that same cycle. Reading 0x40 leaves the capture unchanged.
- R11: Clear addresses and unmapped addresses read zero. Writes to any address other than 0x30 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 12 | Write data (mask width) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clear reads act at the cycle's end |
| rdata | output | 16 | Read data, zero when `rd_en` is low |
| src_evt | input | 12 | Event pulses; bits 2 and 4 are threshold levels |
| abort_vec | input | 16 | Abort reason bits for this cycle |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong clear decode shows up on the very next read of 0x34. Either a neighbouring bit vanishes, or the addressed bit survives. The bench therefore clears each source in turn from an all-set state and reads the raw view in the following cycle. A lost event-versus-clear priority, or a capture that fails to accumulate or wipe, is visible one cycle later at 0x34 or 0x80. A mask fault appears immediately on `irq` and 0x2C. These are swept one mask bit at a time.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NSRC       = 12;
  localparam int RXLVL_BIT  = 2;
  localparam int TXLVL_BIT  = 4;
  localparam int ABORT_BIT  = 6;

  localparam logic [7:0] A_MASKED  = 8'h2C;
  localparam logic [7:0] A_MASK    = 8'h30;
  localparam logic [7:0] A_RAW     = 8'h34;
  localparam logic [7:0] A_CLR_ALL = 8'h40;
  localparam logic [7:0] A_CLR_BASE= 8'h44;
  localparam logic [7:0] A_ABORT   = 8'h80;

  function automatic bit is_level(input int idx);
    return (idx == RXLVL_BIT) || (idx == TXLVL_BIT);
  endfunction

  // position of a source among the clearable ones
  function automatic int clr_rank(input int idx);
    int r;
    r = 0;
    for (int k = 0; k < idx; k++)
      if (!is_level(k)) r++;
    return r;
  endfunction

  function automatic logic [7:0] clr_addr(input int idx);
    return A_CLR_BASE + 8'(4 * clr_rank(idx));
  endfunction
endpackage

// File: rtl/irq_clear_decode.sv
module irq_clear_decode
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  output logic [NSRC-1:0]   clr_own,
  output logic              clr_all,
  output logic              clr_abort
);
  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    if (is_level(i)) begin : g_lvl
      assign clr_own[i] = 1'b0;
    end else begin : g_pls
      assign clr_own[i] = rd_en && (addr == ADDR_W'(clr_addr(i)));
    end
  end

  assign clr_all   = rd_en && (addr == ADDR_W'(A_CLR_ALL));
  assign clr_abort = clr_own[ABORT_BIT];
endmodule

// File: rtl/irq_abort_latch.sv
module irq_abort_latch #(
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [ABORT_W-1:0] vec,
  output logic [ABORT_W-1:0] cap,
  output logic               hit
);
  assign hit = |vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else        cap <= (clr ? '0 : cap) | vec;
  end

  a_r10_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && vec == '0) |=> (cap == '0));
  a_r9_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cap & $past(cap)) == $past(cap)));
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_status_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NSRC-1:0]    wdata,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NSRC-1:0]    src_evt,
  input  logic [ABORT_W-1:0] abort_vec,
  output logic               irq
);
  logic [NSRC-1:0]    raw;
  logic [NSRC-1:0]    mask_q;
  logic [NSRC-1:0]    masked;
  logic [NSRC-1:0]    clr_own;
  logic [NSRC-1:0]    set_evt;
  logic               clr_all;
  logic               clr_abort;
  logic               abort_hit;
  logic [ABORT_W-1:0] abort_cap;

  irq_clear_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .rd_en(rd_en),
    .clr_own(clr_own), .clr_all(clr_all), .clr_abort(clr_abort)
  );

  irq_abort_latch #(.ABORT_W(ABORT_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .clr(clr_abort), .vec(abort_vec),
    .cap(abort_cap), .hit(abort_hit)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (is_level(i)) begin : g_lvl
      assign set_evt[i] = 1'b0;
      assign raw[i]     = src_evt[i];
    end else begin : g_pls
      logic bit_q;
      if (i == ABORT_BIT) begin : g_ab
        assign set_evt[i] = src_evt[i] | abort_hit;
      end else begin : g_nab
        assign set_evt[i] = src_evt[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       bit_q <= 1'b0;
        else if (set_evt[i])              bit_q <= 1'b1;
        else if (clr_own[i] || clr_all)   bit_q <= 1'b0;
      end
      assign raw[i] = bit_q;

      a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[i] |=> raw[i]);
      a_r6_clear_own: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_own[i] && !set_evt[i]) |=> !raw[i]);
      a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_evt[i]) |=> !raw[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en && addr == ADDR_W'(A_MASK)) mask_q <= wdata;
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(A_MASKED): rdata = DATA_W'(masked);
        ADDR_W'(A_MASK):   rdata = DATA_W'(mask_q);
        ADDR_W'(A_RAW):    rdata = DATA_W'(raw);
        ADDR_W'(A_ABORT):  rdata = DATA_W'(abort_cap);
        default:           rdata = '0;
      endcase
    end
  end

  a_r6_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_own));
  a_r9_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> raw[ABORT_BIT]);
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: tb/irq_status_regs_test.sv
`timescale 1ns/1ps
module irq_status_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;
  logic [11:0] src_evt = '0;
  logic [15:0] abort_vec = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [11:0] PULSE_ALL = 12'hFEB;

  irq_status_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .src_evt(src_evt), .abort_vec(abort_vec),
    .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [15:0] ab);
    @(negedge clk); src_evt = e; abort_vec = ab;
    @(negedge clk); src_evt = '0; abort_vec = '0;
  endtask

  // event and clear read in one cycle
  task automatic race(input logic [11:0] e, input logic [15:0] ab, input logic [7:0] a);
    @(negedge clk); src_evt = e; abort_vec = ab; addr = a; rd_en = 1'b1;
    @(negedge clk); src_evt = '0; abort_vec = '0; rd_en = 1'b0;
  endtask

  function automatic logic [7:0] clear_of(input int b);
    int n;
    n = 0;
    for (int j = 0; j < b; j++) if (j != 2 && j != 4) n = n + 1;
    return 8'h44 + 8'(n * 4);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [11:0] cur;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h34, d); check("R1 raw", d, 16'h0);
    rd(8'h30, d); check("R1 mask", d, 16'h0);
    rd(8'h2C, d); check("R1 masked", d, 16'h0);
    rd(8'h80, d); check("R1 abort", d, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2 each pulse source sets its own bit
    cur = '0;
    for (int i = 0; i < 12; i++) begin
      if (i == 2 || i == 4) continue;
      pulse(12'(1 << i), 16'h0);
      cur = cur | 12'(1 << i);
      rd(8'h34, d); check("R2 set bit", d, {4'h0, cur});
    end
    // R7 combined clear
    rd(8'h40, d); check("R11 clr-all reads zero", d, 16'h0);
    rd(8'h34, d); check("R7 clear all", d, 16'h0);

    // R6 per-source clear sweep
    for (int i = 0; i < 12; i++) begin
      if (i == 2 || i == 4) continue;
      pulse(12'hFFF, 16'h0);
      rd(8'h34, d); check("R6 all set", d, {4'h0, PULSE_ALL});
      rd(clear_of(i), d); check("R11 clear addr reads zero", d, 16'h0);
      rd(8'h34, d); check("R6 clear only own", d, {4'h0, PULSE_ALL & ~12'(1 << i)});
      rd(8'h40, d);
    end

    // R3 threshold levels follow input and ignore clears
    @(negedge clk); src_evt = 12'h014;
    rd(8'h34, d); check("R3 level follow", d, 16'h0014);
    rd(8'h40, d);
    for (int i = 0; i < 12; i++)
      if (i != 2 && i != 4) rd(clear_of(i), d);
    rd(8'h34, d); check("R3 level survives clears", d, 16'h0014);
    @(negedge clk); src_evt = 12'h0;
    #1 rd(8'h34, d); check("R3 level drops", d, 16'h0);

    // R4/R5 mask sweep, raw = pulse set plus rx level
    pulse(PULSE_ALL, 16'h0);
    @(negedge clk); src_evt = 12'h004;
    for (int i = 0; i < 12; i++) begin
      wr(8'h30, 12'(1 << i));
      rd(8'h30, d); check("R4 mask readback", d, 16'(1 << i));
      rd(8'h2C, d); check("R4 masked view", d, 16'(12'hFEF & 12'(1 << i)));
      check("R5 irq", {15'b0, irq}, {15'b0, (i != 4)});
    end
    wr(8'h30, 12'h0);
    check("R5 irq masked off", {15'b0, irq}, 16'h0);
    // R11 writes elsewhere ignored
    wr(8'h34, 12'h000); wr(8'h44, 12'hFFF); wr(8'h80, 12'hFFF);
    rd(8'h34, d); check("R11 raw unchanged by write", d, 16'h0FEF);
    rd(8'h30, d); check("R11 mask unchanged by write", d, 16'h0);
    rd(8'h3C, d); check("R11 unmapped reads zero", d, 16'h0);
    @(negedge clk); src_evt = 12'h0;
    rd(8'h40, d);

    // R8 event wins over clear
    race(12'h001, 16'h0, clear_of(0));
    rd(8'h34, d); check("R8 own clear race", d, 16'h0001);
    race(12'h200, 16'h0, 8'h40);
    rd(8'h34, d); check("R8 clear-all race", d, 16'h0200);
    rd(8'h40, d);

    // R9 abort accumulation
    pulse(12'h0, 16'h0009);
    pulse(12'h0, 16'h1000);
    rd(8'h80, d); check("R9 abort accumulate", d, 16'h1009);
    rd(8'h34, d); check("R9 abort sets bit 6", d, 16'h0040);
    // R10 combined clear leaves capture
    rd(8'h40, d);
    rd(8'h80, d); check("R10 clr-all keeps capture", d, 16'h1009);
    rd(8'h34, d); check("R7 abort bit cleared", d, 16'h0);
    // R10 dedicated clear wipes capture
    pulse(12'h0, 16'h0002);
    rd(8'h54, d);
    rd(8'h80, d); check("R10 capture wiped", d, 16'h0);
    rd(8'h34, d); check("R10 abort bit cleared", d, 16'h0);
    // R10 reason in same cycle as wipe is kept
    pulse(12'h0, 16'h0800);
    race(12'h0, 16'h0004, 8'h54);
    rd(8'h80, d); check("R10 same-cycle reason kept", d, 16'h0004);
    rd(8'h34, d); check("R8 abort bit kept", d, 16'h0040);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule